// File: doc/BRIEF.md
# Streaming Reed-Solomon (255,239) Systematic Encoder

This block turns a stream of 8-bit message symbols into codewords of a Reed-Solomon code over GF(2^8): 255 symbols per codeword, 239 of them message and 16 of them check symbols, enough to repair up to eight corrupted symbols. A producer offers one symbol per clock with a valid strobe. A start marker on the first symbol of a block opens a new codeword. Message symbols come out unchanged one cycle later. After the 239th symbol the block produces the 16 check symbols by itself on 16 consecutive cycles, and the input is ignored during that time.

The check symbols are the remainder of the shifted message divided by the generator polynomial. The generator's roots are sixteen consecutive powers α^120 … α^135 of the primitive element. The field is built from x^8 + x^7 + x^2 + x + 1. For this root set the generator's coefficients read the same from either end. The division register therefore needs only eight constant multipliers, each made of XOR gates alone. Each multiplier serves a pair of mirrored taps.

Top module: `rs255_encoder`

## Requirements
- R1: A message symbol accepted on a clock edge appears on `out_data` after that edge, with `out_valid` high and `out_parity` low.
- R2: Right after the 239th message symbol is accepted, exactly 16 check symbols follow on the next 16 edges, each with `out_valid` and `out_parity` high.
- R3: The check symbols are the coefficients of x^16·m(x) mod g(x), emitted highest degree first. m(x) has the first message symbol as its x^238 coefficient. g(x) is the product of (x + α^i) for i = 120…135, with α = 0x02 in the field defined by 0x187.
- R4: Every complete 255-symbol output block, read first symbol as the x^254 coefficient, evaluates to zero at each of α^120 … α^135.
- R5: `out_last` is high together with the 16th check symbol and at no other time.
- R6: A start marker with valid clears the division state. A block that starts after an unfinished block gets the same check symbols as a block that starts from reset.
- R7: While check symbols are being produced, `in_valid`, `in_sop` and `in_data` have no effect on the output stream or on the check symbols.
- R8: Cycles with `in_valid` low during the message phase produce no output and leave the check symbols unchanged.
- R9: A new block's start marker is accepted on the cycle right after the edge that emits the last check symbol.
- R10: After reset, `out_valid`, `out_parity` and `out_last` are low.
- R11: A valid symbol without a start marker while no block is open is dropped and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input symbol strobe |
| in_sop | input | 1 | First symbol of a block (qualified by in_valid) |
| in_data | input | 8 | Message symbol |
| out_valid | output | 1 | Output symbol strobe |
| out_data | output | 8 | Message or check symbol |
| out_parity | output | 1 | High while a check symbol is on out_data |
| out_last | output | 1 | High on the 255th symbol of a codeword |

## Verification
The encoder is driven with random messages, an all-zero message and an all-0xFF message. The all-zero case must give all-zero check symbols. The random and all-ones cases exercise every shared multiplier and the mirrored taps, and a wrong coefficient or wrong sharing shows up as a mismatch against a long-division model that uses a table-based multiplier. A block cut short and then restarted separates correct clearing on the start marker from stale state. A block with idle gaps separates correct stalling from a free-running register. Junk stimulus during the check phase, with a back-to-back next block, checks that the input is ignored in that phase and that the handover happens on the right cycle. Independent syndrome evaluation at all sixteen roots confirms every codeword regardless of the model.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int SYM_W      = 8;
  localparam int N_SYM      = (1 << SYM_W) - 1;
  localparam int N_PAR      = 16;
  localparam int K_SYM      = N_SYM - N_PAR;
  localparam int FIRST_ROOT = 120;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h187;

  typedef logic [SYM_W-1:0] sym_t;

  // shift-and-add product in the field
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t p;
    sym_t aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ aa;
      if (aa[SYM_W-1]) aa = (aa << 1) ^ FIELD_POLY[SYM_W-1:0];
      else             aa = aa << 1;
    end
    return p;
  endfunction

  function automatic sym_t alpha_pow(input int e);
    sym_t p;
    p = sym_t'(1);
    for (int i = 0; i < (e % N_SYM); i++) p = gf_mul(p, sym_t'(2));
    return p;
  endfunction

  // coefficient j of prod (x + alpha^i), i = FIRST_ROOT .. FIRST_ROOT+N_PAR-1
  function automatic sym_t gen_coef(input int j);
    sym_t g [N_PAR+1];
    sym_t root;
    for (int k = 0; k <= N_PAR; k++) g[k] = '0;
    g[0] = sym_t'(1);
    for (int i = 0; i < N_PAR; i++) begin
      root = alpha_pow(FIRST_ROOT + i);
      for (int k = N_PAR; k > 0; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
    end
    return g[j];
  endfunction
endpackage

// File: rtl/rs_cmul.sv
// Multiply by a constant: each output bit is an XOR of selected input bits.
module rs_cmul
  import rs_pkg::*;
#(
  parameter sym_t COEF = sym_t'(1)
) (
  input  sym_t a,
  output sym_t y
);
  sym_t col [SYM_W];

  for (genvar i = 0; i < SYM_W; i++) begin : g_col
    localparam sym_t COL = gf_mul(COEF, sym_t'(1) << i);
    assign col[i] = COL;
  end

  always_comb begin
    y = '0;
    for (int i = 0; i < SYM_W; i++) begin
      if (a[i]) y = y ^ col[i];
    end
  end
endmodule

// File: rtl/rs_seq.sv
// Block sequencing: idle, message phase, check-symbol phase.
module rs_seq
  import rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sop,
  output logic acc,        // message symbol taken this cycle
  output logic blk_start,  // taken symbol opens a block
  output logic shift_par,  // check symbol shifted out this cycle
  output logic last_par,   // final check symbol this cycle
  output logic idle,
  output logic in_msg
);
  localparam int CW = $clog2(K_SYM);

  typedef enum logic [1:0] {S_IDLE, S_MSG, S_PAR} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic          last_msg;

  assign idle      = (st == S_IDLE);
  assign in_msg    = (st == S_MSG);
  assign shift_par = (st == S_PAR);
  assign acc       = in_valid && (in_sop ? !shift_par : in_msg);
  assign blk_start = acc && in_sop;
  assign idx       = blk_start ? '0 : cnt;
  assign last_msg  = acc && (idx == CW'(K_SYM - 1));
  assign last_par  = shift_par && (cnt == CW'(N_PAR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (last_msg) begin
      st  <= S_PAR;
      cnt <= '0;
    end else if (acc) begin
      st  <= S_MSG;
      cnt <= idx + 1'b1;
    end else if (shift_par) begin
      if (last_par) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the check phase never runs past its 16 slots
  p_par_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_par |-> (cnt < CW'(N_PAR)));
  // R2: the check phase begins right after the final message symbol
  p_par_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_msg |=> shift_par && (cnt == '0));
  // R9: the block closes right after its last check symbol
  p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_par |=> idle);
endmodule

// File: rtl/rs255_encoder.sv
module rs255_encoder
  import rs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_parity,
  output logic             out_last
);
  localparam int HALF = N_PAR / 2;

  logic acc, blk_start, shift_par, last_par, idle, in_msg;

  rs_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .acc       (acc),
    .blk_start (blk_start),
    .shift_par (shift_par),
    .last_par  (last_par),
    .idle      (idle),
    .in_msg    (in_msg)
  );

  sym_t par_q [N_PAR];
  sym_t fb;
  sym_t prod [HALF+1];  // prod[0]: monic end coefficient, i.e. fb itself
  sym_t tap  [N_PAR];

  assign fb      = in_data ^ (blk_start ? '0 : par_q[N_PAR-1]);
  assign prod[0] = fb;

  // one multiplier per mirrored coefficient pair (j, N_PAR-j)
  for (genvar j = 1; j <= HALF; j++) begin : g_mul
    rs_cmul #(.COEF(gen_coef(j))) u_mul (.a(fb), .y(prod[j]));
  end

  for (genvar j = 0; j < N_PAR; j++) begin : g_tap
    localparam int M = (j <= HALF) ? j : (N_PAR - j);
    assign tap[j] = prod[M];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_PAR; j++) par_q[j] <= '0;
    end else if (acc) begin
      par_q[0] <= tap[0];
      for (int j = 1; j < N_PAR; j++)
        par_q[j] <= (blk_start ? '0 : par_q[j-1]) ^ tap[j];
    end else if (shift_par) begin
      par_q[0] <= '0;
      for (int j = 1; j < N_PAR; j++) par_q[j] <= par_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_parity <= 1'b0;
      out_last   <= 1'b0;
    end else begin
      out_valid  <= acc || shift_par;
      out_data   <= acc ? in_data : par_q[N_PAR-1];
      out_parity <= shift_par;
      out_last   <= last_par;
    end
  end

  // R1: accepted message symbols pass through unchanged
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && !out_parity && (out_data == $past(in_data)));
  // R2: check symbols come on consecutive cycles until the last one
  p_par_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_parity && !out_last) |=> out_valid && out_parity);
  // R5: the end marker only rides on a check symbol
  p_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid && out_parity);
  // R7: input during the check phase never becomes message output
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_par |=> out_parity);
  // R8: a gap in the message phase gives no output
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_msg && !in_valid) |=> !out_valid);
  // R11: stray symbols outside a block are dropped
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !(in_valid && in_sop)) |=> !out_valid);
endmodule

// File: tb/rs255_encoder_bench.sv
module rs255_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid, out_parity, out_last;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  int stray  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  rs255_encoder u_rs255_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_parity(out_parity), .out_last(out_last)
  );

  // log / antilog tables for field 0x187
  int exp_t [510];
  int log_t [256];
  int gpoly [17];

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 255];
  endfunction

  typedef struct {
    logic [7:0] d;
    bit         par;
    bit         last;
    bit         first;
    string      tag;
  } item_t;
  item_t exp_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit par, input bit last,
                      input bit first, input string tag);
    item_t it;
    it.d = d; it.par = par; it.last = last; it.first = first; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drive(input bit v, input bit s, input logic [7:0] d);
    in_valid = v; in_sop = s; in_data = d;
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor with independent syndrome evaluation (R4)
  int syn [16];
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        stray++;
        errors++; checks++;
        $display("FAIL R11 actual=%0h expected=no output at %0t", out_data, $time);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(out_data == it.d, it.par ? {it.tag, " R3 symbol"} : "R1 data",
              int'(out_data), int'(it.d));
        check(out_parity == it.par, "R2 parity flag", int'(out_parity), int'(it.par));
        check(out_last == it.last, "R5 last flag", int'(out_last), int'(it.last));
        for (int r = 0; r < 16; r++) begin
          if (it.first) syn[r] = 0;
          syn[r] = gmul(syn[r], exp_t[(120 + r) % 255]) ^ int'(out_data);
        end
        if (it.last)
          for (int r = 0; r < 16; r++) check(syn[r] == 0, "R4 syndrome", syn[r], 0);
      end
    end
  end

  task automatic run_block(input int kind, input string tag, input bit gaps,
                           input bit junk, input int ndata);
    logic [7:0] msg [239];
    int a [255];
    for (int i = 0; i < 239; i++)
      msg[i] = (kind == 0) ? 8'($urandom) : (kind == 1) ? 8'h00 : 8'hFF;
    for (int i = 0; i < 255; i++) a[i] = 0;
    for (int i = 0; i < 239; i++) a[254 - i] = int'(msg[i]);
    for (int i = 254; i >= 16; i--) begin
      int c;
      c = a[i];
      if (c != 0)
        for (int j = 0; j <= 16; j++) a[i - 16 + j] ^= gmul(c, gpoly[j]);
    end
    for (int i = 0; i < ndata; i++) begin
      push(msg[i], 1'b0, 1'b0, i == 0, tag);
      drive(1'b1, i == 0, msg[i]);
      if (gaps && (i % 7 == 3)) begin
        drive(1'b0, 1'($urandom), 8'($urandom));  // R8 gap
        drive(1'b0, 1'b0, 8'($urandom));
      end
    end
    if (ndata == 239) begin
      for (int p = 0; p < 16; p++) push(8'(a[15 - p]), 1'b1, p == 15, 1'b0, tag);
      for (int p = 0; p < 16; p++)  // R7 junk or idle during check phase
        if (junk) drive(1'b1, 1'($urandom), 8'($urandom));
        else      drive(1'b0, 1'b0, 8'h00);
    end
  endtask

  initial begin
    exp_t[0] = 1;
    for (int i = 1; i < 510; i++) begin
      int v;
      v = exp_t[i-1] << 1;
      if (v > 255) v ^= 'h187;
      exp_t[i] = v;
    end
    for (int i = 0; i < 256; i++) log_t[i] = 0;
    for (int i = 0; i < 255; i++) log_t[exp_t[i]] = i;
    for (int j = 0; j < 17; j++) gpoly[j] = 0;
    gpoly[0] = 1;
    for (int r = 120; r <= 135; r++)
      for (int j = 16; j >= 0; j--)
        gpoly[j] = gmul(gpoly[j], exp_t[r % 255]) ^ ((j > 0) ? gpoly[j-1] : 0);

    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(!out_valid, "R10 out_valid", int'(out_valid), 0);
    check(!out_parity, "R10 out_parity", int'(out_parity), 0);
    check(!out_last, "R10 out_last", int'(out_last), 0);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 8'h00);

    // R11: symbols without a start marker while idle
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 8'($urandom));
    drive(1'b0, 1'b0, 8'h00);
    drive(1'b0, 1'b0, 8'h00);
    check(stray == 0, "R11 stray outputs", stray, 0);

    run_block(0, "R3", 1'b0, 1'b0, 239);
    run_block(1, "R3", 1'b0, 1'b0, 239);
    run_block(2, "R3", 1'b0, 1'b0, 239);
    run_block(0, "R6", 1'b0, 1'b0, 40);        // cut short
    run_block(0, "R6", 1'b0, 1'b0, 239);       // restart clears state
    run_block(0, "R8", 1'b1, 1'b1, 239);       // gaps, then R7 junk
    run_block(0, "R9", 1'b0, 1'b1, 239);       // back to back
    run_block(2, "R9", 1'b0, 1'b0, 239);
    repeat (4) drive(1'b0, 1'b0, 8'h00);
    check(exp_q.size() == 0, "R2 missing outputs", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule